// File: doc/BRIEF.md
# 3-Wire ADC Readout Controller

This block sits on the host side of a 16-bit successive-approximation converter wired for its three-wire chip-select arrangement. The converter's serial data input is tied high, and the controller drives the convert-start line and the serial clock while it listens on the serial data output. A single request on `start_req` runs one full cycle. The controller raises convert-start to begin a conversion and shapes that line over the conversion window. It then clocks out the sixteen result bits, most significant first, and hands the word to the system with a one-cycle valid strobe.

Two framing options are selected by `busy_mode`, which is captured when a request is accepted. In the polled option, convert-start stays high for the whole worst-case conversion time. Its falling edge makes the MSB appear, and sixteen serial clock pulses are issued while the line is low. In the flagged option, convert-start is dropped shortly after the conversion begins and is kept low. The controller waits for the converter to pull its data line low, which marks the end of the conversion. It then issues seventeen pulses, and the bit ahead of the first falling edge is the flag itself. If no flag shows up within the worst-case conversion time plus a margin, the cycle is abandoned and a timeout pulse is given. Every cycle ends with convert-start held high for an acquisition interval, which releases the converter's data line. The line then returns low.

Top module: `adc3w_reader`

## Requirements
- R1: While reset is asserted and after it is released, `cnv_o`, `sclk_o`, `result_vld_o` and `timeout_o` are low. `sdi_o` is high at all times.
- R2: A `start_req` high on a clock edge while the controller is idle makes `cnv_o` high from that edge on.
- R3: With `busy_mode` = 0 at the request, `cnv_o` stays high for exactly CNV_MAX clock cycles and then falls.
- R4: With `busy_mode` = 0, exactly DATA_W serial clock falling edges occur while `cnv_o` is low. `sdo_i` is sampled in the last high cycle before each falling edge. The first sample is the MSB, which is bit 15 of `result_o`.
- R5: With `busy_mode` = 1 at the request, `cnv_o` stays high for exactly CNV_HI cycles, with CNV_HI below CNV_MIN. It then stays low, and no serial clock is issued until `sdo_i` is seen low.
- R6: With `busy_mode` = 1, exactly DATA_W+1 falling edges occur after the low flag. The sample before the first falling edge is discarded, and the following DATA_W samples form the word, MSB first.
- R7: `sclk_o` is low when idle. It is high only while `cnv_o` is low. Each high phase and each low phase between pulses lasts `clk_div`+1 clock cycles.
- R8: `result_vld_o` is a single-cycle pulse given the cycle after the last bit is sampled, with `result_o` holding the assembled word.
- R9: After the last bit, or after a timeout, `cnv_o` is high for exactly ACQ cycles and then low, and the controller is idle again.
- R10: In busy mode, if `sdo_i` has not gone low CNV_MAX+MARGIN cycles after `cnv_o` rose, `timeout_o` pulses for one cycle. At the same moment `cnv_o` goes high, no serial clock is issued and no valid pulse is given.
- R11: `start_req` while a cycle is running has no effect. The cycle gives one result, and `cnv_o` rises only twice: once at the start and once at the end.
- R12: A change of `busy_mode` during a running cycle does not alter that cycle's framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | Request one conversion-and-readout cycle (sampled when idle) |
| busy_mode | input | 1 | 0: polled framing, 1: busy-flag framing (captured at request) |
| clk_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| sdo_i | input | 1 | Serial data from the converter (pulled high when released) |
| cnv_o | output | 1 | Convert-start / chip-select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Serial data to the converter, constant high |
| result_o | output | DATA_W | Last assembled conversion word |
| result_vld_o | output | 1 | One-cycle strobe marking a new `result_o` |
| timeout_o | output | 1 | One-cycle strobe when no busy flag arrived in time |

## Verification
Words such as alternating nibbles, all zeros, all ones and only the two end bits set go through both framings. A swapped bit order, a lost MSB or a shift off by one between modes then shows up as a wrong word. Each frame runs with a different serial clock divider, so a half-period that ignores the divider or counts one cycle too many is seen apart from a data fault. Frames with a stray request and a flipped mode bit in mid-cycle separate a controller that latches its mode and ignores requests from one that restarts or reframes. A converter model that never raises its flag tests the timeout path and the recovery that follows it.

// File: rtl/adc3w_pkg.sv
package adc3w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV_HI,
    ST_BUSY_WAIT,
    ST_READ,
    ST_ACQ
  } adc3w_state_e;

endpackage

// File: rtl/adc3w_timer.sv
// Phase timer shared by all controller states: cleared on a state change,
// counting while enabled.
module adc3w_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/adc3w_sclk_gen.sv
// Serial clock pulse generator. Issues n_edges pulses while run is high,
// each phase lasting half+1 cycles. smp_stb marks the last high cycle
// before a falling edge.
module adc3w_sclk_gen #(
  parameter int DIV_W  = 4,
  parameter int EDGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  half,
  input  logic [EDGE_W-1:0] n_edges,
  output logic              sclk,
  output logic              smp_stb,
  output logic [EDGE_W-1:0] edge_cnt,
  output logic              done
);

  logic [DIV_W-1:0]  div_q, div_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              sclk_q, sclk_d;
  logic              phase_end;
  logic              all_sent;

  assign phase_end = (div_q == half);
  assign all_sent  = (edge_q == n_edges);

  always_comb begin
    div_d  = div_q;
    edge_d = edge_q;
    sclk_d = sclk_q;
    if (!run) begin
      div_d  = '0;
      edge_d = '0;
      sclk_d = 1'b0;
    end else if (all_sent) begin
      sclk_d = 1'b0;
    end else if (phase_end) begin
      div_d  = '0;
      sclk_d = ~sclk_q;
      if (sclk_q) begin
        edge_d = edge_q + 1'b1;
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      edge_q <= edge_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk     = sclk_q;
  assign smp_stb  = run && sclk_q && phase_end && !all_sent;
  assign edge_cnt = edge_q;
  assign done     = run && all_sent;

endmodule

// File: rtl/adc3w_shifter.sv
// MSB-first capture register.
module adc3w_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) begin
      word_d = {word_q[DATA_W-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/adc3w_reader.sv
module adc3w_reader
  import adc3w_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 4,
  parameter int CNV_MIN = 40,
  parameter int CNV_MAX = 60,
  parameter int CNV_HI  = 4,
  parameter int ACQ     = 10,
  parameter int MARGIN  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              busy_mode,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o,
  output logic              timeout_o
);

  localparam int CNT_W  = $clog2(CNV_MAX + MARGIN + ACQ + 1);
  localparam int EDGE_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_NB_HI = CNT_W'(CNV_MAX - 1);
  localparam logic [CNT_W-1:0] LAST_B_HI  = CNT_W'((CNV_HI < CNV_MIN ? CNV_HI : CNV_MIN - 1) - 1);
  localparam logic [CNT_W-1:0] LAST_WAIT  = CNT_W'(CNV_MAX + MARGIN - CNV_HI - 1);
  localparam logic [CNT_W-1:0] LAST_ACQ   = CNT_W'(ACQ - 1);
  localparam logic [EDGE_W-1:0] EDGES_NB  = EDGE_W'(DATA_W);
  localparam logic [EDGE_W-1:0] EDGES_B   = EDGE_W'(DATA_W + 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  adc3w_state_e      state_q, state_d;
  logic              mode_q, mode_d;
  logic              cnv_q, cnv_d;
  logic              vld_q, vld_d;
  logic              tmo_q, tmo_d;
  logic [DATA_W-1:0] res_q, res_d;

  logic [CNT_W-1:0]  tmr;
  logic              tmr_clr;
  logic              tmr_en;
  logic              sclk_run;
  logic [EDGE_W-1:0] n_edges;
  logic              smp_stb;
  logic [EDGE_W-1:0] edge_cnt;
  logic              sclk_done;
  logic              shift_en;
  logic [DATA_W-1:0] word;

  adc3w_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (tmr_en),
    .clr   (tmr_clr),
    .cnt   (tmr)
  );

  assign sclk_run = (state_q == ST_READ);
  assign n_edges  = mode_q ? EDGES_B : EDGES_NB;

  adc3w_sclk_gen #(.DIV_W(DIV_W), .EDGE_W(EDGE_W)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (sclk_run),
    .half     (clk_div),
    .n_edges  (n_edges),
    .sclk     (sclk_o),
    .smp_stb  (smp_stb),
    .edge_cnt (edge_cnt),
    .done     (sclk_done)
  );

  // In flagged framing the sample ahead of the first falling edge is the flag.
  assign shift_en = smp_stb && !(mode_q && (edge_cnt == '0));

  adc3w_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (shift_en),
    .din      (sdo_i),
    .word     (word)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    vld_d   = 1'b0;
    tmo_d   = 1'b0;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d = ST_CNV_HI;
          mode_d  = busy_mode;
        end
      end
      ST_CNV_HI: begin
        if (mode_q) begin
          if (tmr == LAST_B_HI) state_d = ST_BUSY_WAIT;
        end else begin
          if (tmr == LAST_NB_HI) state_d = ST_READ;
        end
      end
      ST_BUSY_WAIT: begin
        if (!sdo_i) begin
          state_d = ST_READ;
        end else if (tmr == LAST_WAIT) begin
          state_d = ST_ACQ;
          tmo_d   = 1'b1;
        end
      end
      ST_READ: begin
        if (sclk_done) begin
          state_d = ST_ACQ;
          vld_d   = 1'b1;
          res_d   = word;
        end
      end
      ST_ACQ: begin
        if (tmr == LAST_ACQ) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    cnv_d   = (state_d == ST_CNV_HI) || (state_d == ST_ACQ);
    tmr_clr = (state_d != state_q);
    tmr_en  = (state_q != ST_IDLE);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      cnv_q   <= 1'b0;
      vld_q   <= 1'b0;
      tmo_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cnv_q   <= cnv_d;
      vld_q   <= vld_d;
      tmo_q   <= tmo_d;
      res_q   <= res_d;
    end
  end

  assign cnv_o        = cnv_q;
  assign sdi_o        = 1'b1;
  assign result_o     = res_q;
  assign result_vld_o = vld_q;
  assign timeout_o    = tmo_q;

endmodule

// File: rtl/adc3w_reader_chk.sv
module adc3w_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic cnv_o,
  input logic sclk_o,
  input logic result_vld_o,
  input logic timeout_o
);

  // R2 / R9: convert-start rises only on a request or at the end of a cycle
  assert_cnv_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> ($past(start_req) || result_vld_o || timeout_o));

  // R7: serial clock is high only while convert-start is low
  assert_sclk_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cnv_o);

  // R8: valid is a single-cycle strobe
  assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |=> !result_vld_o);

  // R9: the result ends the frame with convert-start high and clock low
  assert_vld_ends_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |-> (cnv_o && !sclk_o));

  // R10: timeout releases the converter and gives no result
  assert_tmo_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (cnv_o && !result_vld_o && !sclk_o));

  // R10: timeout is a single-cycle strobe
  assert_tmo_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

endmodule

bind adc3w_reader adc3w_reader_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_req    (start_req),
  .cnv_o        (cnv_o),
  .sclk_o       (sclk_o),
  .result_vld_o (result_vld_o),
  .timeout_o    (timeout_o)
);

// File: tb/adc3w_reader_bench.sv
`timescale 1ns/1ps
module adc3w_reader_bench;

  localparam int DATA_W  = 16;
  localparam int DIV_W   = 4;
  localparam int CNV_MIN = 40;
  localparam int CNV_MAX = 60;
  localparam int CNV_HI  = 4;
  localparam int ACQ     = 10;
  localparam int MARGIN  = 20;
  localparam int DEV_CNV = 50;
  localparam int WD_CYC  = 100000;

  logic              clk;
  logic              rst_n;
  logic              start_req;
  logic              busy_mode;
  logic [DIV_W-1:0]  clk_div;
  logic              sdo_r;
  logic              cnv_o;
  logic              sclk_o;
  logic              sdi_o;
  logic [DATA_W-1:0] result_o;
  logic              result_vld_o;
  logic              timeout_o;

  adc3w_reader #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .CNV_MIN(CNV_MIN), .CNV_MAX(CNV_MAX),
    .CNV_HI(CNV_HI), .ACQ(ACQ), .MARGIN(MARGIN)
  ) u_adc3w_reader (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .busy_mode    (busy_mode),
    .clk_div      (clk_div),
    .sdo_i        (sdo_r),
    .cnv_o        (cnv_o),
    .sclk_o       (sclk_o),
    .sdi_o        (sdi_o),
    .result_o     (result_o),
    .result_vld_o (result_vld_o),
    .timeout_o    (timeout_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk;
  int n_fail;
  bit done_flag;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // ---------------- converter model ----------------
  logic [DATA_W-1:0] dev_word;
  bit dev_busy;
  bit dev_silent;
  bit dev_armed;
  int dev_idx;

  always @(posedge cnv_o) begin
    sdo_r = 1'b1;
    dev_idx = -1;
    if (dev_armed) begin
      dev_armed = 1'b0;
      if (dev_busy && !dev_silent) begin
        repeat (DEV_CNV) @(posedge clk);
        if (!cnv_o) begin
          sdo_r = 1'b0;
          dev_idx = DATA_W;
        end
      end
    end
  end

  always @(negedge cnv_o) begin
    if (!dev_busy) begin
      dev_idx = DATA_W - 1;
      sdo_r = dev_word[dev_idx];
    end
  end

  always @(negedge sclk_o) begin
    if (!cnv_o && dev_idx >= 0) begin
      dev_idx--;
      sdo_r = (dev_idx >= 0) ? dev_word[dev_idx] : 1'b1;
    end
  end

  // ---------------- scoreboard monitor ----------------
  logic [DATA_W-1:0] exp_q[$];
  int vld_cnt;
  int falls, rises;
  int hmin, hmax, lmin, lmax;
  int run_len;
  bit in_gap;
  bit p_sclk, p_cnv;

  initial begin
    p_sclk = 0; p_cnv = 0; run_len = 0; in_gap = 0; vld_cnt = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (result_vld_o) begin
          vld_cnt++;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected result", longint'(result_o), 0);
          end else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            chk(result_o == e, "R4/R6/R8", "result word", longint'(result_o), longint'(e));
          end
        end
        if (cnv_o && !p_cnv) rises++;
        if (cnv_o) in_gap = 0;
        if (sclk_o != p_sclk) begin
          if (!sclk_o) begin
            falls++;
            if (run_len < hmin) hmin = run_len;
            if (run_len > hmax) hmax = run_len;
            in_gap = 1;
          end else if (in_gap) begin
            if (run_len < lmin) lmin = run_len;
            if (run_len > lmax) lmax = run_len;
          end
          run_len = 1;
        end else begin
          run_len++;
        end
        p_sclk = sclk_o;
        p_cnv = cnv_o;
      end
    end
  end

  task automatic clear_stats();
    falls = 0; rises = 0; hmin = 999; hmax = 0; lmin = 999; lmax = 0;
  endtask

  // ---------------- driver ----------------
  task automatic run_frame(input logic [DATA_W-1:0] w, input bit mode, input int div,
                           input bit poke, input bit flip);
    int hi;
    int q;
    int v0;
    int gap;
    busy_mode = mode;
    clk_div = DIV_W'(div);
    dev_word = w;
    dev_busy = mode;
    dev_silent = 0;
    dev_armed = 1;
    exp_q.push_back(w);
    clear_stats();
    v0 = vld_cnt;
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(cnv_o == 1'b1, "R2", "cnv after request", longint'(cnv_o), 1);
    hi = 0;
    while (cnv_o) begin
      hi++;
      @(negedge clk);
    end
    if (mode) chk(hi == CNV_HI, "R5", "cnv high length busy", hi, CNV_HI);
    else      chk(hi == CNV_MAX, "R3", "cnv high length polled", hi, CNV_MAX);
    if (flip) busy_mode = ~mode;
    if (mode) begin
      gap = 0;
      while (sdo_r && gap < 100) begin
        chk(sclk_o == 1'b0, "R5", "no clock before flag", longint'(sclk_o), 0);
        gap++;
        @(negedge clk);
      end
    end
    if (poke) begin
      repeat (3) @(negedge clk);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
    end
    while (!result_vld_o && !timeout_o) @(negedge clk);
    chk(result_vld_o == 1'b1, "R8", "valid seen", longint'(result_vld_o), 1);
    q = 0;
    while (cnv_o) begin
      q++;
      @(negedge clk);
    end
    chk(q == ACQ, "R9", "acquisition high length", q, ACQ);
    if (mode) chk(falls == DATA_W + 1, "R6", "falling edges busy", falls, DATA_W + 1);
    else      chk(falls == DATA_W, "R4", "falling edges polled", falls, DATA_W);
    chk(hmin == div + 1 && hmax == div + 1, "R7", "sclk high phase", hmax, div + 1);
    chk(lmin == div + 1 && lmax == div + 1, "R7", "sclk low phase", lmax, div + 1);
    chk(vld_cnt - v0 == 1, poke ? "R11" : "R8", "one result per cycle", vld_cnt - v0, 1);
    chk(rises == 2, poke ? "R11" : "R9", "cnv rises per cycle", rises, 2);
    if (flip) chk(1'b1, "R12", "mode flip framing (edge count above)", 0, 0);
    busy_mode = mode;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_timeout();
    int t;
    int v0;
    busy_mode = 1'b1;
    clk_div = DIV_W'(1);
    dev_busy = 1;
    dev_silent = 1;
    dev_armed = 1;
    clear_stats();
    v0 = vld_cnt;
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    t = 1;
    while (!timeout_o && t < 1000) begin
      @(negedge clk);
      t++;
    end
    chk(t == CNV_MAX + MARGIN + 1, "R10", "timeout sample index", t, CNV_MAX + MARGIN + 1);
    chk(cnv_o == 1'b1, "R10", "cnv high at timeout", longint'(cnv_o), 1);
    @(negedge clk);
    chk(timeout_o == 1'b0, "R10", "timeout one cycle", longint'(timeout_o), 0);
    while (cnv_o) @(negedge clk);
    chk(falls == 0, "R10", "no sclk on timeout", falls, 0);
    chk(vld_cnt == v0, "R10", "no result on timeout", vld_cnt - v0, 0);
    repeat (DEV_CNV + 20) @(negedge clk);
    dev_silent = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    n_chk = 0; n_fail = 0; done_flag = 0;
    rst_n = 1'b0;
    start_req = 1'b0;
    busy_mode = 1'b0;
    clk_div = '0;
    sdo_r = 1'b1;
    dev_word = '0; dev_busy = 0; dev_silent = 0; dev_armed = 0; dev_idx = -1;
    clear_stats();
    repeat (4) @(negedge clk);
    chk(cnv_o == 0 && sclk_o == 0, "R1", "outputs in reset", {cnv_o, sclk_o}, 0);
    chk(result_vld_o == 0 && timeout_o == 0, "R1", "strobes in reset",
        {result_vld_o, timeout_o}, 0);
    chk(sdi_o == 1'b1, "R1", "sdi high", longint'(sdi_o), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cnv_o == 0 && sclk_o == 0 && result_vld_o == 0 && timeout_o == 0, "R1",
        "idle after reset", {cnv_o, sclk_o, result_vld_o, timeout_o}, 0);

    run_frame(16'hA5C3, 1'b0, 0, 1'b0, 1'b0);
    run_frame(16'h0000, 1'b0, 1, 1'b0, 1'b0);
    run_frame(16'hFFFF, 1'b0, 3, 1'b0, 1'b0);
    run_frame(16'h8001, 1'b1, 0, 1'b0, 1'b0);
    run_frame(16'h7FFE, 1'b1, 2, 1'b0, 1'b0);
    run_frame(16'h3C96, 1'b1, 1, 1'b0, 1'b0);
    // R11, R12: stray request and mode flip while running
    run_frame(16'h1234, 1'b0, 1, 1'b1, 1'b1);
    run_frame(16'h5A5A, 1'b1, 0, 1'b1, 1'b1);
    // R10: no busy flag, then recovery
    run_timeout();
    run_frame(16'hC0DE, 1'b1, 1, 1'b0, 1'b0);
    chk(sdi_o == 1'b1, "R1", "sdi still high", longint'(sdi_o), 1);
    chk(exp_q.size() == 0, "R8", "all expected results seen", exp_q.size(), 0);

    done_flag = 1;
    summary();
    $finish;
  end

endmodule